// File: doc/BRIEF.md
# Exception Entry and Return Stacking Sequencer

This block runs beside a small processor core and carries out the memory traffic needed to take an exception and to come back from it. The core stalls while the block works. When a request is accepted at an instruction boundary, the block lowers the stack pointer by one frame of eight words. It writes the caller-saved registers, the link register, the program counter and the status word into that frame. It then loads the link register with a reserved token that is not a code address, and fetches the handler address from a vector table indexed by the exception number.

Because the frame holds exactly what an ordinary subroutine may clobber, a handler can be built with the normal calling convention. It returns with a plain branch to its link register. The block watches every branch target. A target in the reserved token range is not a real jump: it starts the reverse sequence, which reads the frame back, restores every saved register and raises the stack pointer again.

Register indices on the register-file port are r0..r12 = 0..12, stack pointer = 13, link register = 14, program counter = 15, status word = 16.

Top module: `exc_stacker`

## Requirements
- R1: A request is taken only in a cycle where the block is idle, `exc_req` is high and `insn_boundary` is high. If a return branch arrives in the same idle cycle as a request, the return is served first and the request is not taken in that cycle.
- R2: On entry the stack pointer is written with its old value minus 32 before any frame write. The frame is stored at the new stack pointer with these byte offsets: 0 r0, 4 r1, 8 r2, 12 r3, 16 r12, 20 link register, 24 program counter, 28 status word.
- R3: After the frame is written, the link register holds 0xFFFFFFF9.
- R4: The handler address is read from byte address 4 × exception number. A vector word with bit 0 set is written to the program counter with bit 0 cleared.
- R5: A vector word with bit 0 clear leaves the program counter unwritten and raises `fault` for exactly one cycle, after which the block is idle.
- R6: While idle, a valid branch whose target has bits 31..4 all ones drives `ret_hit` high in the same cycle and starts a return. Any other branch target is ignored: no memory access occurs and the block stays idle.
- R7: A return reads the frame from offset 28 down to offset 0, writes each word back to its register, and then writes the stack pointer with the frame base plus 32.
- R8: `busy` is high from the cycle after acceptance until the sequence ends. While `busy` is low, the block issues no memory request and no register write.
- R9: A memory request that is not yet granted by `mem_ready` keeps `mem_valid`, `mem_addr` and `mem_write` unchanged in the next cycle.
- R10: During reset, `busy`, `mem_valid`, `rf_wr_en` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request, held until taken |
| exc_num | input | NUM_W | Exception number, used as the vector index |
| insn_boundary | input | 1 | High when the current instruction has completed |
| branch_valid | input | 1 | The core is taking a branch this cycle |
| branch_target | input | 32 | Target address of that branch |
| ret_hit | output | 1 | The branch is an exception return and must not load the program counter |
| rf_rd_idx | output | 5 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data, same cycle |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | 5 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| busy | output | 1 | Stall the core |
| fault | output | 1 | One-cycle pulse for a vector with bit 0 clear |

## Verification
A wrong slot counter or base register shows up as a frame word at the wrong offset. It also shows up as a register restored from the wrong word. The first case is visible in memory once `busy` falls after entry. The second is visible in the register file once `busy` falls after return. A stuck or mis-sequenced state shows up as `busy` staying high, or as memory traffic with `busy` low. An error in token or vector decode shows up in the first cycle of the branch through `ret_hit`, or one cycle after the vector read through `fault` and the program counter value.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int          WORD_W      = 32;
  localparam int          REG_IDX_W   = 5;
  localparam int          FRAME_WORDS = 8;
  localparam int          SLOT_W      = $clog2(FRAME_WORDS);
  localparam logic [WORD_W-1:0] FRAME_BYTES = WORD_W'(FRAME_WORDS * 4);

  localparam logic [REG_IDX_W-1:0] IDX_R12 = 5'd12;
  localparam logic [REG_IDX_W-1:0] IDX_SP  = 5'd13;
  localparam logic [REG_IDX_W-1:0] IDX_LR  = 5'd14;
  localparam logic [REG_IDX_W-1:0] IDX_PC  = 5'd15;
  localparam logic [REG_IDX_W-1:0] IDX_PSR = 5'd16;

  localparam logic [WORD_W-1:0] RET_TOKEN = 32'hFFFF_FFF9;
  localparam logic [WORD_W-1:0] RET_MASK  = 32'hFFFF_FFF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SP_DEC,
    ST_PUSH,
    ST_LR_SET,
    ST_VEC,
    ST_SP_RD,
    ST_POP,
    ST_SP_INC
  } seq_state_t;

  // register held in a given frame slot (ascending address order)
  function automatic logic [REG_IDX_W-1:0] frame_reg(input logic [SLOT_W-1:0] slot);
    case (slot)
      3'd4:    frame_reg = IDX_R12;
      3'd5:    frame_reg = IDX_LR;
      3'd6:    frame_reg = IDX_PC;
      3'd7:    frame_reg = IDX_PSR;
      default: frame_reg = {2'b00, slot};
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] slot_offset(input logic [SLOT_W-1:0] slot);
    slot_offset = {{(WORD_W-SLOT_W-2){1'b0}}, slot, 2'b00};
  endfunction

  function automatic logic is_ret_target(input logic [WORD_W-1:0] t);
    is_ret_target = ((t & RET_MASK) == RET_MASK);
  endfunction

endpackage

// File: rtl/exc_ret_detect.sv
module exc_ret_detect
  import exc_pkg::*;
(
  input  logic              branch_valid,
  input  logic [WORD_W-1:0] branch_target,
  output logic              ret_hit
);

  assign ret_hit = branch_valid && is_ret_target(branch_target);

endmodule

// File: rtl/exc_frame_addr.sv
module exc_frame_addr
  import exc_pkg::*;
#(
  parameter int                NUM_W    = 6,
  parameter logic [WORD_W-1:0] VEC_BASE = '0
) (
  input  logic [WORD_W-1:0] sp_now,
  input  logic [WORD_W-1:0] base,
  input  logic [SLOT_W-1:0] slot,
  input  logic [NUM_W-1:0]  num,
  output logic [WORD_W-1:0] sp_dec,
  output logic [WORD_W-1:0] sp_inc,
  output logic [WORD_W-1:0] slot_addr,
  output logic [WORD_W-1:0] vec_addr
);

  localparam int PAD_W = WORD_W - NUM_W - 2;

  assign sp_dec    = sp_now - FRAME_BYTES;
  assign sp_inc    = base + FRAME_BYTES;
  assign slot_addr = base + slot_offset(slot);
  assign vec_addr  = VEC_BASE + {{PAD_W{1'b0}}, num, 2'b00};

endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_pkg::*;
#(
  parameter int NUM_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exc_req,
  input  logic [NUM_W-1:0]     exc_num,
  input  logic                 insn_boundary,
  input  logic                 ret_hit,
  input  logic [WORD_W-1:0]    rf_rd_data,
  input  logic                 mem_ready,
  input  logic [WORD_W-1:0]    mem_rdata,
  input  logic [WORD_W-1:0]    sp_dec,
  input  logic [WORD_W-1:0]    sp_inc,
  input  logic [WORD_W-1:0]    slot_addr,
  input  logic [WORD_W-1:0]    vec_addr,
  output logic [REG_IDX_W-1:0] rf_rd_idx,
  output logic                 rf_wr_en,
  output logic [REG_IDX_W-1:0] rf_wr_idx,
  output logic [WORD_W-1:0]    rf_wr_data,
  output logic                 mem_valid,
  output logic                 mem_write,
  output logic [WORD_W-1:0]    mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  output logic                 busy,
  output logic                 fault,
  output logic [WORD_W-1:0]    base_q,
  output logic [SLOT_W-1:0]    slot_q,
  output logic [NUM_W-1:0]     num_q,
  output logic                 stack_phase,
  output logic                 vec_phase,
  output logic                 unstack_phase,
  output logic                 pc_load
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_WORDS - 1);

  seq_state_t            state_q, state_d;
  logic [WORD_W-1:0]     base_d;
  logic [SLOT_W-1:0]     slot_d;
  logic [NUM_W-1:0]      num_d;
  logic                  fault_d;

  always_comb begin
    state_d    = state_q;
    base_d     = base_q;
    slot_d     = slot_q;
    num_d      = num_q;
    fault_d    = 1'b0;
    rf_rd_idx  = IDX_SP;
    rf_wr_en   = 1'b0;
    rf_wr_idx  = IDX_SP;
    rf_wr_data = '0;
    mem_valid  = 1'b0;
    mem_write  = 1'b0;
    mem_addr   = '0;
    mem_wdata  = '0;
    pc_load    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ret_hit) begin
          state_d = ST_SP_RD;
        end else if (exc_req && insn_boundary) begin
          state_d = ST_SP_DEC;
          num_d   = exc_num;
        end
      end
      ST_SP_DEC: begin
        rf_rd_idx  = IDX_SP;
        rf_wr_en   = 1'b1;
        rf_wr_idx  = IDX_SP;
        rf_wr_data = sp_dec;
        base_d     = sp_dec;
        slot_d     = '0;
        state_d    = ST_PUSH;
      end
      ST_PUSH: begin
        rf_rd_idx = frame_reg(slot_q);
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = slot_addr;
        mem_wdata = rf_rd_data;
        if (mem_ready) begin
          if (slot_q == LAST_SLOT) state_d = ST_LR_SET;
          else                     slot_d  = slot_q + 1'b1;
        end
      end
      ST_LR_SET: begin
        rf_wr_en   = 1'b1;
        rf_wr_idx  = IDX_LR;
        rf_wr_data = RET_TOKEN;
        state_d    = ST_VEC;
      end
      ST_VEC: begin
        mem_valid = 1'b1;
        mem_addr  = vec_addr;
        if (mem_ready) begin
          state_d = ST_IDLE;
          if (mem_rdata[0]) begin
            rf_wr_en   = 1'b1;
            rf_wr_idx  = IDX_PC;
            rf_wr_data = mem_rdata & ~32'd1;
            pc_load    = 1'b1;
          end else begin
            fault_d = 1'b1;
          end
        end
      end
      ST_SP_RD: begin
        rf_rd_idx = IDX_SP;
        base_d    = rf_rd_data;
        slot_d    = LAST_SLOT;
        state_d   = ST_POP;
      end
      ST_POP: begin
        mem_valid = 1'b1;
        mem_addr  = slot_addr;
        if (mem_ready) begin
          rf_wr_en   = 1'b1;
          rf_wr_idx  = frame_reg(slot_q);
          rf_wr_data = mem_rdata;
          if (slot_q == '0) state_d = ST_SP_INC;
          else              slot_d  = slot_q - 1'b1;
        end
      end
      ST_SP_INC: begin
        rf_wr_en   = 1'b1;
        rf_wr_idx  = IDX_SP;
        rf_wr_data = sp_inc;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      slot_q  <= '0;
      num_q   <= '0;
      fault   <= 1'b0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      slot_q  <= slot_d;
      num_q   <= num_d;
      fault   <= fault_d;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign stack_phase   = (state_q == ST_SP_DEC) || (state_q == ST_PUSH);
  assign vec_phase     = (state_q == ST_VEC);
  assign unstack_phase = (state_q == ST_SP_RD) || (state_q == ST_POP) ||
                         (state_q == ST_SP_INC);

endmodule

// File: rtl/exc_stacker.sv
module exc_stacker
  import exc_pkg::*;
#(
  parameter int                NUM_W    = 6,
  parameter logic [WORD_W-1:0] VEC_BASE = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exc_req,
  input  logic [NUM_W-1:0]     exc_num,
  input  logic                 insn_boundary,
  input  logic                 branch_valid,
  input  logic [WORD_W-1:0]    branch_target,
  output logic                 ret_hit,
  output logic [REG_IDX_W-1:0] rf_rd_idx,
  input  logic [WORD_W-1:0]    rf_rd_data,
  output logic                 rf_wr_en,
  output logic [REG_IDX_W-1:0] rf_wr_idx,
  output logic [WORD_W-1:0]    rf_wr_data,
  output logic                 mem_valid,
  output logic                 mem_write,
  output logic [WORD_W-1:0]    mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic                 mem_ready,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 busy,
  output logic                 fault
);

  logic [WORD_W-1:0] base_q;
  logic [SLOT_W-1:0] slot_q;
  logic [NUM_W-1:0]  num_q;
  logic [WORD_W-1:0] sp_dec, sp_inc, slot_addr, vec_addr;
  logic              stack_phase, vec_phase, unstack_phase, pc_load;
  logic              ret_raw;

  exc_ret_detect u_ret (
    .branch_valid  (branch_valid),
    .branch_target (branch_target),
    .ret_hit       (ret_raw)
  );

  // a return is only meaningful while the core is running
  assign ret_hit = ret_raw && !busy;

  exc_frame_addr #(
    .NUM_W    (NUM_W),
    .VEC_BASE (VEC_BASE)
  ) u_addr (
    .sp_now    (rf_rd_data),
    .base      (base_q),
    .slot      (slot_q),
    .num       (num_q),
    .sp_dec    (sp_dec),
    .sp_inc    (sp_inc),
    .slot_addr (slot_addr),
    .vec_addr  (vec_addr)
  );

  exc_seq_ctrl #(
    .NUM_W (NUM_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_req       (exc_req),
    .exc_num       (exc_num),
    .insn_boundary (insn_boundary),
    .ret_hit       (ret_hit),
    .rf_rd_data    (rf_rd_data),
    .mem_ready     (mem_ready),
    .mem_rdata     (mem_rdata),
    .sp_dec        (sp_dec),
    .sp_inc        (sp_inc),
    .slot_addr     (slot_addr),
    .vec_addr      (vec_addr),
    .rf_rd_idx     (rf_rd_idx),
    .rf_wr_en      (rf_wr_en),
    .rf_wr_idx     (rf_wr_idx),
    .rf_wr_data    (rf_wr_data),
    .mem_valid     (mem_valid),
    .mem_write     (mem_write),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .busy          (busy),
    .fault         (fault),
    .base_q        (base_q),
    .slot_q        (slot_q),
    .num_q         (num_q),
    .stack_phase   (stack_phase),
    .vec_phase     (vec_phase),
    .unstack_phase (unstack_phase),
    .pc_load       (pc_load)
  );

endmodule

// File: rtl/exc_stacker_chk.sv
module exc_stacker_chk
  import exc_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 insn_boundary,
  input logic                 ret_hit,
  input logic                 mem_valid,
  input logic                 mem_ready,
  input logic                 mem_write,
  input logic [WORD_W-1:0]    mem_addr,
  input logic                 rf_wr_en,
  input logic [REG_IDX_W-1:0] rf_wr_idx,
  input logic [WORD_W-1:0]    rf_wr_data,
  input logic                 fault,
  input logic                 stack_phase,
  input logic                 vec_phase,
  input logic                 unstack_phase,
  input logic                 pc_load
);

  // R1: no start without an instruction boundary or a return
  a_r1_wait_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !insn_boundary && !ret_hit) |=> !busy);

  // R2: frame traffic on entry is all writes
  a_r2_push_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_phase && mem_valid) |-> mem_write);

  // R3: the vector fetch is preceded by the token load into lr
  a_r3_token_before_vec: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_phase) |-> $past(rf_wr_en && rf_wr_idx == IDX_LR && rf_wr_data == RET_TOKEN));

  // R4: the vector fetch is an aligned read
  a_r4_vec_read: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_phase && mem_valid) |-> (!mem_write && mem_addr[1:0] == 2'b00));

  // R5: a fault never follows a pc load, and lasts one cycle
  a_r5_fault_no_pc: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !$past(pc_load));
  a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  // R7: unstacking only reads memory
  a_r7_pop_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    (unstack_phase && mem_valid) |-> !mem_write);

  // R8: idle means no memory or register traffic
  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !rf_wr_en));

  // R9: a waiting request holds still
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

endmodule

bind exc_stacker exc_stacker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .insn_boundary (insn_boundary),
  .ret_hit       (ret_hit),
  .mem_valid     (mem_valid),
  .mem_ready     (mem_ready),
  .mem_write     (mem_write),
  .mem_addr      (mem_addr),
  .rf_wr_en      (rf_wr_en),
  .rf_wr_idx     (rf_wr_idx),
  .rf_wr_data    (rf_wr_data),
  .fault         (fault),
  .stack_phase   (stack_phase),
  .vec_phase     (vec_phase),
  .unstack_phase (unstack_phase),
  .pc_load       (pc_load)
);

// File: tb/test_exc_stacker.sv
`timescale 1ns/1ps
module test_exc_stacker;

  localparam int NUM_W = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [NUM_W-1:0] exc_num = '0;
  logic        insn_boundary = 1'b0;
  logic        branch_valid = 1'b0;
  logic [31:0] branch_target = '0;
  logic        ret_hit;
  logic [4:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;
  logic        rf_wr_en;
  logic [4:0]  rf_wr_idx;
  logic [31:0] rf_wr_data;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata;
  logic        busy, fault;

  always #2 clk = ~clk;

  exc_stacker #(.NUM_W(NUM_W)) i_exc_stacker (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_num(exc_num),
    .insn_boundary(insn_boundary), .branch_valid(branch_valid),
    .branch_target(branch_target), .ret_hit(ret_hit),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .fault(fault)
  );

  // register file and memory models around the block
  logic [31:0] rf  [0:16];
  logic [31:0] mem [0:1023];
  assign rf_rd_data = (rf_rd_idx <= 5'd16) ? rf[rf_rd_idx] : 32'h0;
  assign mem_rdata  = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (rf_wr_en && rf_wr_idx <= 5'd16) rf[rf_wr_idx] <= rf_wr_data;
    if (mem_valid && mem_ready && mem_write) mem[mem_addr[11:2]] <= mem_wdata;
  end

  always @(negedge clk) mem_ready <= (($urandom % 3) != 0);

  int n_chk = 0, n_bad = 0;
  int fault_cnt = 0, txn_cnt = 0, hold_bad = 0;
  bit arm_first = 0, first_was_write = 0;
  logic prev_wait = 0, prev_write = 0;
  logic [31:0] prev_addr = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (fault) fault_cnt++;
    if (mem_valid && mem_ready) begin
      txn_cnt++;
      if (arm_first) begin first_was_write = mem_write; arm_first = 0; end
    end
    if (rst_n && prev_wait &&
        (!mem_valid || mem_addr != prev_addr || mem_write != prev_write)) hold_bad++;
    prev_wait  <= mem_valid && !mem_ready;
    prev_addr  <= mem_addr;
    prev_write <= mem_write;
  end

  logic [31:0] saved [0:7];
  logic [31:0] saved_sp;

  // frame slot to register index, as stated in R2
  function automatic int slot_reg(input int k);
    case (k)
      4: return 12;
      5: return 14;
      6: return 15;
      7: return 16;
      default: return k;
    endcase
  endfunction

  function automatic bit token_like(input logic [31:0] t);
    return t[31:4] == 28'hFFFFFFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wait_idle(input string req);
    int w = 0;
    @(negedge clk);
    while (busy && w < 2000) begin @(negedge clk); w++; end
    if (busy) chk({req, " watchdog"}, 32'd1, 32'd0);
  endtask

  task automatic do_entry(input int num, input bit hold_bound);
    int fc0;
    logic [31:0] vec;
    for (int k = 0; k < 8; k++) saved[k] = rf[slot_reg(k)];
    saved_sp = rf[13];
    fc0 = fault_cnt;
    exc_num = num[NUM_W-1:0];
    if (hold_bound) begin
      exc_req = 1; insn_boundary = 0;
      repeat (3 + $urandom % 4) @(negedge clk);
      chk("R1 no boundary busy", {31'd0, busy}, 32'd0);
    end
    exc_req = 1; insn_boundary = 1;
    @(negedge clk);
    chk("R8 busy after accept", {31'd0, busy}, 32'd1);
    exc_req = 0; insn_boundary = 0;
    wait_idle("R8");
    @(negedge clk);
    chk("R2 sp lowered", rf[13], saved_sp - 32'd32);
    for (int k = 0; k < 8; k++)
      chk("R2 frame word", mem[((saved_sp - 32'd32 + 32'(4*k)) >> 2) & 32'h3FF], saved[k]);
    chk("R3 lr token", rf[14], 32'hFFFF_FFF9);
    vec = mem[num];
    if (vec[0]) begin
      chk("R4 pc from vector", rf[15], vec & ~32'd1);
      chk("R5 no fault", 32'(fault_cnt), 32'(fc0));
    end else begin
      chk("R5 fault pulse", 32'(fault_cnt), 32'(fc0 + 1));
      chk("R5 pc kept", rf[15], saved[6]);
    end
  endtask

  task automatic do_return(input bit with_req);
    rf[0] <= $urandom; rf[1] <= $urandom; rf[2] <= $urandom; rf[3] <= $urandom;
    rf[12] <= $urandom; rf[15] <= $urandom; rf[16] <= $urandom;
    @(negedge clk);
    branch_target = 32'hFFFF_FFF0 | 32'($urandom % 16);
    branch_valid = 1;
    if (with_req) begin
      exc_req = 1; insn_boundary = 1; exc_num = 6'd7;
    end
    arm_first = 1;
    #1;
    chk("R6 ret_hit", {31'd0, ret_hit}, 32'd1);
    @(negedge clk);
    branch_valid = 0; exc_req = 0; insn_boundary = 0;
    wait_idle("R7");
    @(negedge clk);
    chk("R7 first access is read", {31'd0, first_was_write}, 32'd0);
    if (with_req) chk("R1 return wins, no entry", {31'd0, busy}, 32'd0);
    chk("R7 sp restored", rf[13], saved_sp);
    for (int k = 0; k < 8; k++) chk("R7 reg restored", rf[slot_reg(k)], saved[k]);
  endtask

  task automatic ignore_branch();
    int t0;
    logic [31:0] tgt;
    do tgt = $urandom; while (token_like(tgt));
    if ($urandom % 2) tgt = 32'hFFFF_FFE9;
    t0 = txn_cnt;
    branch_target = tgt; branch_valid = 1;
    #1;
    chk("R6 no ret_hit", {31'd0, ret_hit}, 32'd0);
    @(negedge clk);
    branch_valid = 0;
    @(negedge clk);
    chk("R6 stays idle", {31'd0, busy}, 32'd0);
    chk("R6 no memory traffic", 32'(txn_cnt), 32'(t0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int i = 0; i < 17; i++) rf[i] <= $urandom;
    rf[13] <= 32'h0000_0E00;
    for (int i = 0; i < 1024; i++) mem[i] <= 32'h0;
    for (int i = 0; i < 64; i++) mem[i] <= ($urandom & 32'h0000_3FFE) | 32'd1;
    mem[5] <= $urandom & 32'hFFFF_FFFE;
    repeat (3) @(negedge clk);
    chk("R10 busy", {31'd0, busy}, 32'd0);
    chk("R10 mem_valid", {31'd0, mem_valid}, 32'd0);
    chk("R10 rf_wr_en", {31'd0, rf_wr_en}, 32'd0);
    chk("R10 fault", {31'd0, fault}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    do_entry(3, 1'b1);
    do_return(1'b0);
    do_entry(5, 1'b0);
    do_return(1'b1);
    do_entry(47, 1'b1);
    do_return(1'b0);
    for (int r = 0; r < 24; r++) begin
      int n;
      n = (r % 7 == 3) ? 5 : int'($urandom % 48);
      ignore_branch();
      do_entry(n, ($urandom % 2) == 1);
      repeat ($urandom % 5) @(negedge clk);
      do_return(r % 4 == 1);
    end
    chk("R9 held requests", 32'(hold_bad), 32'd0);
    finish_run();
  end

endmodule